// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block holds a 16-bit processor flag word and updates its six status bits from the outcome of an 8-bit or 16-bit add, subtract or logic operation. The ALU drives the two operands, the result, the carry or borrow out of the top bit of the active size, the operation size, the operation class and a per-flag update enable. The register derives carry, parity, half-carry, zero, sign and overflow from these inputs and stores the enabled ones on the next clock edge.

The three control bits (trap, interrupt enable, direction) are written directly through a separate per-bit write enable. This path is independent of the status update, so both can happen in the same cycle. The packed word is always visible on one output. The seven unused bit positions always read as zero.

Top module: `status_flag_word`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flags` reads 16'h0000 until the first update or control write takes effect.
- R2: Packing: carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10, overflow at bit 11. Bits 1, 3, 5 and 12 to 15 always read 0.
- R3: Zero flag is 1 exactly when the result over the active size is zero (low 8 bits when `op_wide`=0, all 16 when `op_wide`=1). The upper byte of `res` is ignored for byte operations.
- R4: Sign flag equals the top bit of the active size (`res[7]` for byte, `res[15]` for word).
- R5: Parity flag is 1 when `res[7:0]` holds an even number of one bits, for both sizes.
- R6: For add (`op_class`=2'b00) and subtract (`op_class`=2'b01), half-carry is the carry from bit 3 into bit 4 of an add, or the borrow of a subtract at that position.
- R7: For add and subtract, carry takes `carry_out` (carry of an add, borrow of a subtract). A logic operation (`op_class`=2'b10 or 2'b11) clears carry.
- R8: Overflow is signed overflow of the active size. For an add it is set when both operands share a sign that differs from the result. For a subtract it is set when the operands differ in sign and the result sign differs from the first operand. A logic operation clears overflow.
- R9: A logic operation leaves half-carry unchanged.
- R10: `upd_en` bit order is carry 0, parity 1, half-carry 2, zero 3, sign 4, overflow 5. A status bit whose enable is 0 keeps its value.
- R11: `ctl_we`/`ctl_wdata` bit order is trap 0, interrupt enable 1, direction 2. An enabled bit loads its data on the clock edge. Control bits change only through this path, and this path never changes status bits.
- R12: With `op_valid` low and `ctl_we` zero, `flags` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An ALU result is presented this cycle |
| op_wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| op_class | input | 2 | 00 add, 01 subtract, 1x logic |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| carry_out | input | 1 | Carry or borrow out of the top bit of the active size |
| upd_en | input | 6 | Per status flag update enable |
| ctl_we | input | 3 | Per control bit write enable |
| ctl_wdata | input | 3 | Control bit write data |
| flags | output | 16 | Packed flag word |

## Verification
Random byte and word adds and subtracts with true results check every derived flag against an independent signed and nibble arithmetic model. Random logic operations with arbitrary results show that carry and overflow clear while half-carry stays. Garbage in the upper byte of byte operations shows that zero and sign use the right size. Directed cases pin exact flag words (0x7F+1, 0x8000+0x8000, 0-1, a zero logic result). Partial enable masks, idle cycles and lone control writes show that each untouched bit holds.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W   = 16;
  localparam int NUM_ST   = 6;
  localparam int NUM_CTL  = 3;

  // status vector index
  localparam int ST_CF = 0;
  localparam int ST_PF = 1;
  localparam int ST_AF = 2;
  localparam int ST_ZF = 3;
  localparam int ST_SF = 4;
  localparam int ST_OF = 5;

  // bit positions in the packed word, indexed by status / control index
  localparam int ST_POS  [NUM_ST]  = '{0, 2, 4, 6, 7, 11};
  localparam int CTL_POS [NUM_CTL] = '{8, 9, 10};

  typedef enum logic [1:0] {
    OPC_ADD   = 2'b00,
    OPC_SUB   = 2'b01,
    OPC_LOGIC = 2'b10,
    OPC_LOG2  = 2'b11
  } op_class_e;

  function automatic logic even_parity8(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic nibble_carry(input logic a4, input logic b4, input logic r4);
    return a4 ^ b4 ^ r4;
  endfunction

  function automatic logic signed_ovf(input logic sa, input logic sb, input logic sr,
                                      input logic is_sub);
    logic sb_eff;
    sb_eff = is_sub ? ~sb : sb;
    return (sa == sb_eff) && (sr != sa);
  endfunction
endpackage

// File: rtl/flag_status_calc.sv
module flag_status_calc
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              op_valid,
  input  logic              op_wide,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              carry_out,
  input  logic [NUM_ST-1:0] upd_en,
  output logic [NUM_ST-1:0] st_value,
  output logic [NUM_ST-1:0] st_wmask
);
  localparam int W_MSB = DATA_W - 1;
  localparam int B_MSB = BYTE_W - 1;

  logic is_logic, is_sub;
  logic sa, sb, sr, zero_res;

  assign is_logic = op_class[1];
  assign is_sub   = (op_class == OPC_SUB);
  assign sa       = op_wide ? opa[W_MSB] : opa[B_MSB];
  assign sb       = op_wide ? opb[W_MSB] : opb[B_MSB];
  assign sr       = op_wide ? res[W_MSB] : res[B_MSB];
  assign zero_res = op_wide ? (res == '0) : (res[B_MSB:0] == '0);

  always_comb begin
    st_value        = '0;
    st_value[ST_CF] = is_logic ? 1'b0 : carry_out;
    st_value[ST_PF] = even_parity8(res[7:0]);
    st_value[ST_AF] = nibble_carry(opa[4], opb[4], res[4]);
    st_value[ST_ZF] = zero_res;
    st_value[ST_SF] = sr;
    st_value[ST_OF] = is_logic ? 1'b0 : signed_ovf(sa, sb, sr, is_sub);
  end

  always_comb begin
    st_wmask = '0;
    if (op_valid) begin
      st_wmask = upd_en;
      if (is_logic) st_wmask[ST_AF] = 1'b0;
    end
  end
endmodule

// File: rtl/flag_bit_bank.sv
module flag_bit_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wmask,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (wmask[i]) q[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/status_flag_word.sv
module status_flag_word
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_wide,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              carry_out,
  input  logic [5:0]        upd_en,
  input  logic [2:0]        ctl_we,
  input  logic [2:0]        ctl_wdata,
  output logic [15:0]       flags
);
  logic [NUM_ST-1:0]  st_value, st_wmask, st_q;
  logic [NUM_CTL-1:0] ctl_q;

  flag_status_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_calc (
    .op_valid (op_valid),
    .op_wide  (op_wide),
    .op_class (op_class),
    .opa      (opa),
    .opb      (opb),
    .res      (res),
    .carry_out(carry_out),
    .upd_en   (upd_en),
    .st_value (st_value),
    .st_wmask (st_wmask)
  );

  flag_bit_bank #(.N(NUM_ST)) u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .wmask(st_wmask),
    .wdata(st_value),
    .q    (st_q)
  );

  flag_bit_bank #(.N(NUM_CTL)) u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .wmask(ctl_we),
    .wdata(ctl_wdata),
    .q    (ctl_q)
  );

  always_comb begin
    flags = '0;
    for (int i = 0; i < NUM_ST; i++)  flags[ST_POS[i]]  = st_q[i];
    for (int j = 0; j < NUM_CTL; j++) flags[CTL_POS[j]] = ctl_q[j];
  end
endmodule

// File: rtl/status_flag_word_chk.sv
module status_flag_word_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_class,
  input logic [5:0]  upd_en,
  input logic [2:0]  ctl_we,
  input logic [5:0]  st_wmask,
  input logic [15:0] flags
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0000);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && ctl_we == 3'b000) |=> $stable(flags));

  p_logic_clear_cf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class[1] && upd_en[0]) |=> !flags[0]);

  p_logic_clear_of_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class[1] && upd_en[5]) |=> !flags[11]);

  p_logic_keep_af_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class[1]) |=> $stable(flags[4]));

  p_no_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !upd_en[3]) |=> $stable(flags[6]));

  p_mask_within_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wmask & ~upd_en) == 6'b0);

  p_ctl_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we == 3'b000) |=> $stable(flags[10:8]));

  p_status_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> $stable({flags[11], flags[7:6], flags[4], flags[2], flags[0]}));
endmodule

bind status_flag_word status_flag_word_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .op_class(op_class),
  .upd_en  (upd_en),
  .ctl_we  (ctl_we),
  .st_wmask(st_wmask),
  .flags   (flags)
);

// File: tb/test_status_flag_word.sv
module test_status_flag_word;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_wide, carry_out;
  logic [1:0]  op_class;
  logic [15:0] opa, opb, res;
  logic [5:0]  upd_en;
  logic [2:0]  ctl_we, ctl_wdata;
  logic [15:0] flags;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_word i_status_flag_word (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_wide(op_wide),
    .op_class(op_class), .opa(opa), .opb(opb), .res(res),
    .carry_out(carry_out), .upd_en(upd_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .flags(flags)
  );

  task automatic check_bit(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
    end
  endtask

  task automatic check_word(string tag, logic [15:0] exp);
    checks++;
    if (flags !== exp) begin
      failures++;
      $display("FAIL %s flags actual=%h expected=%h", tag, flags, exp);
    end
  endtask

  task automatic check_all();
    check_bit("R7", "carry",  flags[0],  exp_w[0]);
    check_bit("R5", "parity", flags[2],  exp_w[2]);
    check_bit("R6", "half",   flags[4],  exp_w[4]);
    check_bit("R3", "zero",   flags[6],  exp_w[6]);
    check_bit("R4", "sign",   flags[7],  exp_w[7]);
    check_bit("R8", "ovf",    flags[11], exp_w[11]);
    check_bit("R11", "trap",  flags[8],  exp_w[8]);
    check_bit("R11", "ien",   flags[9],  exp_w[9]);
    check_bit("R11", "dir",   flags[10], exp_w[10]);
    checks++;
    if ((flags & 16'hF02A) != 0) begin
      failures++;
      $display("FAIL R2 unused actual=%h expected=0000", flags & 16'hF02A);
    end
  endtask

  function automatic int to_signed(logic [15:0] v, bit wide);
    if (wide) return v[15] ? int'(v) - 65536 : int'(v);
    return v[7] ? int'(v[7:0]) - 256 : int'(v[7:0]);
  endfunction

  // reference update of the expected word
  function automatic logic [15:0] model(logic [15:0] cur, bit v, bit wide, logic [1:0] cls,
                                        logic [15:0] a, logic [15:0] b, logic [15:0] r,
                                        bit c, logic [5:0] en, logic [2:0] we, logic [2:0] wd);
    logic [15:0] nw;
    int ones, s, lo, hi;
    bit cf, pf, af, zf, sf, of;
    nw = cur;
    if (v) begin
      ones = 0;
      for (int k = 0; k < 8; k++) ones += r[k];
      pf = (ones % 2) == 0;
      zf = wide ? (r == 0) : (r[7:0] == 0);
      sf = wide ? r[15] : r[7];
      lo = wide ? -32768 : -128;
      hi = wide ? 32767 : 127;
      if (cls == 2'b00) begin
        s = to_signed(a, wide) + to_signed(b, wide);
        of = (s < lo) || (s > hi);
        af = (int'(a[3:0]) + int'(b[3:0])) > 15;
        cf = c;
      end else if (cls == 2'b01) begin
        s = to_signed(a, wide) - to_signed(b, wide);
        of = (s < lo) || (s > hi);
        af = a[3:0] < b[3:0];
        cf = c;
      end else begin
        of = 0; cf = 0; af = cur[4];
      end
      if (en[0]) nw[0]  = cf;
      if (en[1]) nw[2]  = pf;
      if (en[2]) nw[4]  = af;
      if (en[3]) nw[6]  = zf;
      if (en[4]) nw[7]  = sf;
      if (en[5]) nw[11] = of;
    end
    for (int j = 0; j < 3; j++) if (we[j]) nw[8+j] = wd[j];
    return nw;
  endfunction

  task automatic apply(bit v, bit wide, logic [1:0] cls, logic [15:0] a, logic [15:0] b,
                       logic [15:0] r, bit c, logic [5:0] en, logic [2:0] we, logic [2:0] wd);
    op_valid = v; op_wide = wide; op_class = cls; opa = a; opb = b; res = r;
    carry_out = c; upd_en = en; ctl_we = we; ctl_wdata = wd;
    exp_w = model(exp_w, v, wide, cls, a, b, r, c, en, we, wd);
    @(posedge clk);
    #(CLK_PERIOD/4);
    op_valid = 0; ctl_we = 0;
  endtask

  // true ALU result for add/sub; upper byte of byte results is junk
  task automatic arith(bit wide, logic [1:0] cls, logic [15:0] a, logic [15:0] b,
                       logic [5:0] en, logic [2:0] we, logic [2:0] wd);
    logic [16:0] w;
    logic [8:0]  n;
    logic [15:0] r;
    bit c;
    if (wide) begin
      w = (cls == 2'b01) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      r = w[15:0]; c = w[16];
    end else begin
      n = (cls == 2'b01) ? ({1'b0, a[7:0]} - {1'b0, b[7:0]}) : ({1'b0, a[7:0]} + {1'b0, b[7:0]});
      r = {8'($urandom), n[7:0]}; c = n[8];
    end
    apply(1, wide, cls, a, b, r, c, en, we, wd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    exp_w = 16'h0;
    rst_n = 0; op_valid = 0; op_wide = 0; op_class = 0; opa = 0; opb = 0; res = 0;
    carry_out = 0; upd_en = 0; ctl_we = 0; ctl_wdata = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_word("R1", 16'h0000);
    rst_n = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    check_word("R1", 16'h0000);

    // directed: byte 7F + 1 -> 80h
    arith(0, 2'b00, 16'h007F, 16'h0001, 6'h3F, 0, 0);
    check_word("R2", 16'h0890);
    check_all();
    // word 8000 + 8000 -> 0 with carry and overflow
    arith(1, 2'b00, 16'h8000, 16'h8000, 6'h3F, 0, 0);
    check_word("R3", 16'h0845);
    // byte 0 - 1 -> FF, borrows
    arith(0, 2'b01, 16'h0000, 16'h0001, 6'h3F, 0, 0);
    check_word("R6", 16'h0095);
    // logic with zero result: CF/OF cleared, AF kept (1)
    apply(1, 0, 2'b10, 16'h00F0, 16'h000F, 16'hAB00, 1, 6'h3F, 0, 0);
    check_word("R9", 16'h0054);
    // control write only
    apply(0, 0, 0, 0, 0, 0, 0, 0, 3'b101, 3'b111);
    check_word("R11", 16'h0554);
    // partial enable: only sign written
    arith(1, 2'b00, 16'h7FFF, 16'h0001, 6'b010000, 0, 0);
    check_word("R10", 16'h05D4);
    // idle hold
    apply(0, 1, 2'b00, 16'hFFFF, 16'hFFFF, 16'h0000, 1, 6'h3F, 0, 3'b010);
    check_word("R12", 16'h05D4);

    for (int it = 0; it < 600; it++) begin
      logic [1:0] cls;
      bit wide, v;
      logic [5:0] en;
      logic [2:0] we;
      cls  = 2'($urandom);
      wide = 1'($urandom);
      v    = ($urandom % 8) != 0;
      en   = ($urandom % 4 == 0) ? 6'($urandom) : 6'h3F;
      we   = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      if (!v)
        apply(0, wide, cls, 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
              en, we, 3'($urandom));
      else if (cls[1])
        apply(1, wide, cls, 16'($urandom), 16'($urandom),
              ($urandom % 8 == 0) ? 16'(($urandom % 2) << 8) : 16'($urandom),
              1'($urandom), en, we, 3'($urandom));
      else
        arith(wide, cls, 16'($urandom), 16'($urandom), en, we, 3'($urandom));
      check_all();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule